// File: doc/BRIEF.md
# Display Controller Configuration Register Block

This block is a 32-bit memory-mapped slave that holds the configuration of a palette-based display pipeline. A host issues one word access per request pulse. The block decodes the address to one of these targets: a 256-entry colour lookup window, a three-entry cursor colour set, a 512-entry cursor bitmap window, a control word, the frame base address, the cursor coordinates, or the horizontal and vertical display size. It answers each access one cycle later. Colour lookup and cursor bitmap writes are not stored here. They leave through registered write ports that feed RAMs in the pixel pipeline.

The horizontal size is written in units of four pixels. The vertical size is written as a count of half lines. The block scales both values on the way in and undoes the scaling on read-back. A three-bit field of the control word is decoded into a pixel depth. Video timing offsets are accepted and have no effect. One reserved address clears the whole configuration and pulses a clear strobe for the external tables. The interrupt line goes high after a completed frame refresh, and any register write takes it low.

Top module: `disp_regif`

## Requirements
- R1: `ready_o` is high in the cycle after every cycle in which `req_i` is high, and low otherwise. After reset, every output is zero, except `depth_bpp_o`, which shows 1 for control code 0.
- R2: A write at an offset in 0x800..0xFFF whose bits 2:0 are zero pulses `color_we_o` for one cycle. It presents `color_idx_o` = offset bits 10:3, and `color_rgb_o` = write data bits 23:0 (red 23:16, green 15:8, blue 7:0).
- R3: Writes at 0x508, 0x510 and 0x518 store cursor colours 0, 1 and 2 from write data bits 23:0. Colour k appears on `cur_pal_o[24k+23:24k]`. A read at the same offset returns the stored colour, zero-extended.
- R4: A write at an offset in 0x1000..0x1FFF whose bits 2:0 are zero pulses `pat_we_o` for one cycle. It presents `pat_idx_o` = offset bits 11:3 and `pat_bits_o` = write data bits 15:0.
- R5: A write of v at 0x118 sets `width_px_o` = 4 × (v mod 2^SIZE_W). A read at 0x118 returns width / 4.
- R6: A write of v at 0x150 sets `height_ln_o` = (v / 2) mod 2^SIZE_W. A read at 0x150 returns height × 2, so an odd value reads back with bit 0 cleared.
- R7: A write at 0x300 stores the 32-bit control word, and a read at 0x300 returns it. Bit 10 drives `blank_o` and bit 23 drives `cursor_off_o`.
- R8: `depth_bpp_o` decodes control bits 22:20. Codes 0..5 give 1, 2, 4, 8, 15 and 16. Codes 6 and 7 give 0.
- R9: A write at 0x400 sets `top_o` to the 32-bit data. A write at 0x638 sets `cursor_x_o` = data bits 23:12 and `cursor_y_o` = data bits 11:0.
- R10: A write at 0x100000 clears the control word, frame base, cursor position, both sizes and all cursor colours. It pulses `tbl_clear_o` for one cycle and takes `irq_o` low.
- R11: A `frame_done_i` pulse sets `irq_o` in the next cycle. Any write, to any offset, clears it in the next cycle. If both happen in the same cycle, the set wins. Reads leave `irq_o` unchanged.
- R12: Writes at 0x000, 0x108, 0x110, 0x120 to 0x148 in steps of 8, 0x158 to 0x170 in steps of 8, and 0x200 change no configuration output and pulse no table write port.
- R13: Reads return zero at every offset other than 0x118, 0x150, 0x300 and the three cursor colour offsets. This covers the two table windows, the frame base, the cursor position and any offset whose bits 2:0 are not zero. Writes at such offsets store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 21 | Byte offset of the word |
| wdata_i | input | 32 | Write data |
| ready_o | output | 1 | Access completion, one cycle after the request |
| rdata_o | output | 32 | Read data, valid while ready_o is high |
| frame_done_i | input | 1 | Pulse at the end of each frame refresh |
| irq_o | output | 1 | Frame interrupt |
| color_we_o | output | 1 | Colour lookup RAM write enable |
| color_idx_o | output | 8 | Colour lookup RAM index |
| color_rgb_o | output | 24 | Colour lookup RAM data |
| pat_we_o | output | 1 | Cursor bitmap RAM write enable |
| pat_idx_o | output | 9 | Cursor bitmap RAM index |
| pat_bits_o | output | 16 | Cursor bitmap RAM data |
| tbl_clear_o | output | 1 | Clear strobe for the external tables |
| width_px_o | output | SIZE_W+2 | Display width in pixels |
| height_ln_o | output | SIZE_W | Display height in lines |
| ctrl_o | output | 32 | Stored control word |
| blank_o | output | 1 | Forced blanking |
| cursor_off_o | output | 1 | Cursor disabled |
| depth_bpp_o | output | 5 | Decoded bits per pixel, 0 = none |
| top_o | output | 32 | Frame base address |
| cursor_x_o | output | 12 | Cursor column |
| cursor_y_o | output | 12 | Cursor row |
| cur_pal_o | output | 72 | Three cursor colours, colour k at bits 24k+23:24k |

## Verification
Every result of an access is registered once, at the edge that samples the request. This covers `ready_o`, `rdata_o`, the table write ports, the clear strobe, the configuration outputs and the interrupt. All of them are therefore due in the cycle after the request, and the one-cycle pulses are gone one cycle after that. The bench drives a request at a falling edge and removes it at the next falling edge. It reads every result at that second falling edge, half a cycle after the capturing edge. It checks that pulses have fallen at the following falling edge. A frame pulse is timed the same way, so a frame pulse and a write can be placed in the same cycle to check which one wins.

// File: rtl/disp_regif_pkg.sv
package disp_regif_pkg;

  localparam int unsigned AW     = 21;
  localparam int unsigned DW     = 32;
  localparam int unsigned NCUR   = 3;
  localparam int unsigned RGB_W  = 24;
  localparam int unsigned PAT_W  = 16;

  localparam logic [AW-1:0] A_HSIZE  = 21'h000118;
  localparam logic [AW-1:0] A_VSIZE  = 21'h000150;
  localparam logic [AW-1:0] A_CTRL   = 21'h000300;
  localparam logic [AW-1:0] A_TOP    = 21'h000400;
  localparam logic [AW-1:0] A_CURCOL = 21'h000508;
  localparam logic [AW-1:0] A_CPOS   = 21'h000638;
  localparam logic [AW-1:0] A_CLEAR  = 21'h100000;

  localparam int unsigned BLANK_BIT = 10;
  localparam int unsigned NOCUR_BIT = 23;
  localparam int unsigned DEPTH_LSB = 20;

  typedef enum logic [3:0] {
    TGT_NONE, TGT_COLOR, TGT_CURCOL, TGT_PATTERN, TGT_CTRL, TGT_TOP,
    TGT_CPOS, TGT_HSIZE, TGT_VSIZE, TGT_CLEAR, TGT_TIMING
  } tgt_e;

  // pixel depth from the three-bit control code, 0 means no valid depth
  function automatic logic [4:0] depth_bpp(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd1;
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd8;
      3'd4:    return 5'd15;
      3'd5:    return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  // video timing offsets that are accepted and dropped
  function automatic logic is_timing(input logic [AW-1:0] a);
    return a inside {21'h000, 21'h108, 21'h110, 21'h120, 21'h128, 21'h130,
                     21'h138, 21'h140, 21'h148, 21'h158, 21'h160, 21'h168,
                     21'h170, 21'h200};
  endfunction

endpackage

// File: rtl/disp_addr_decode.sv
module disp_addr_decode
  import disp_regif_pkg::*;
(
  input  logic [AW-1:0] addr_i,
  output tgt_e          tgt_o,
  output logic [8:0]    idx_o
);

  logic on_grid;
  assign on_grid = (addr_i[2:0] == 3'b000);

  always_comb begin
    tgt_o = TGT_NONE;
    idx_o = '0;
    if (on_grid) begin
      if ((addr_i >> 11) == AW'(1)) begin
        tgt_o = TGT_COLOR;
        idx_o = {1'b0, addr_i[10:3]};
      end else if ((addr_i >> 12) == AW'(1)) begin
        tgt_o = TGT_PATTERN;
        idx_o = addr_i[11:3];
      end else if (addr_i inside {A_CURCOL, A_CURCOL + AW'(8), A_CURCOL + AW'(16)}) begin
        tgt_o = TGT_CURCOL;
        idx_o = 9'({7'd0, addr_i[4:3]} - 9'd1);
      end else begin
        case (addr_i)
          A_CTRL:  tgt_o = TGT_CTRL;
          A_TOP:   tgt_o = TGT_TOP;
          A_CPOS:  tgt_o = TGT_CPOS;
          A_HSIZE: tgt_o = TGT_HSIZE;
          A_VSIZE: tgt_o = TGT_VSIZE;
          A_CLEAR: tgt_o = TGT_CLEAR;
          default: tgt_o = is_timing(addr_i) ? TGT_TIMING : TGT_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/disp_depth_decode.sv
module disp_depth_decode
  import disp_regif_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] code_i,
  output logic [4:0] bpp_o
);

  assign bpp_o = depth_bpp(code_i);

  assert_depth_legal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bpp_o inside {5'd0, 5'd1, 5'd2, 5'd4, 5'd8, 5'd15, 5'd16});

  assert_depth_reserved_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i[2:1] == 2'b11) |-> (bpp_o == 5'd0));

endmodule

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_o <= 1'b0;
    else if (set_i) irq_o <= 1'b1;
    else if (clr_i) irq_o <= 1'b0;
  end

  assert_irq_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> irq_o);

  assert_irq_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !irq_o);

  assert_irq_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(irq_o));

endmodule

// File: rtl/disp_regif.sv
module disp_regif
  import disp_regif_pkg::*;
#(
  parameter int unsigned SIZE_W = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [20:0]           addr_i,
  input  logic [31:0]           wdata_i,
  output logic                  ready_o,
  output logic [31:0]           rdata_o,
  input  logic                  frame_done_i,
  output logic                  irq_o,
  output logic                  color_we_o,
  output logic [7:0]            color_idx_o,
  output logic [23:0]           color_rgb_o,
  output logic                  pat_we_o,
  output logic [8:0]            pat_idx_o,
  output logic [15:0]           pat_bits_o,
  output logic                  tbl_clear_o,
  output logic [SIZE_W+1:0]     width_px_o,
  output logic [SIZE_W-1:0]     height_ln_o,
  output logic [31:0]           ctrl_o,
  output logic                  blank_o,
  output logic                  cursor_off_o,
  output logic [4:0]            depth_bpp_o,
  output logic [31:0]           top_o,
  output logic [11:0]           cursor_x_o,
  output logic [11:0]           cursor_y_o,
  output logic [71:0]           cur_pal_o
);

  localparam int unsigned POS_W = 24;

  // decoded access events, named for the assertions
  tgt_e       tgt;
  logic [8:0] idx;
  logic       wr_evt;
  logic       rd_evt;
  logic       clear_evt;

  assign wr_evt    = req_i && we_i;
  assign rd_evt    = req_i && !we_i;
  assign clear_evt = wr_evt && (tgt == TGT_CLEAR);

  disp_addr_decode u_decode (
    .addr_i (addr_i),
    .tgt_o  (tgt),
    .idx_o  (idx)
  );

  // stored configuration
  logic [DW-1:0]     ctrl_q;
  logic [DW-1:0]     top_q;
  logic [POS_W-1:0]  cpos_q;
  logic [SIZE_W-1:0] hsize_q;
  logic [SIZE_W-1:0] vsize_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      top_q   <= '0;
      cpos_q  <= '0;
      hsize_q <= '0;
      vsize_q <= '0;
    end else if (clear_evt) begin
      ctrl_q  <= '0;
      top_q   <= '0;
      cpos_q  <= '0;
      hsize_q <= '0;
      vsize_q <= '0;
    end else if (wr_evt) begin
      case (tgt)
        TGT_CTRL:  ctrl_q  <= wdata_i;
        TGT_TOP:   top_q   <= wdata_i;
        TGT_CPOS:  cpos_q  <= wdata_i[POS_W-1:0];
        TGT_HSIZE: hsize_q <= wdata_i[SIZE_W-1:0];
        TGT_VSIZE: vsize_q <= wdata_i[SIZE_W:1];
        default: ;
      endcase
    end
  end

  // cursor colour set, one register per entry
  for (genvar k = 0; k < NCUR; k++) begin : g_curcol
    logic [RGB_W-1:0] col_q;
    logic             hit;
    assign hit = wr_evt && (tgt == TGT_CURCOL) && (idx[1:0] == 2'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        col_q <= '0;
      else if (clear_evt) col_q <= '0;
      else if (hit)       col_q <= wdata_i[RGB_W-1:0];
    end
    assign cur_pal_o[k*RGB_W +: RGB_W] = col_q;
  end

  // read data, scaled back to the written units
  logic [DW-1:0] rd_val;
  always_comb begin
    case (tgt)
      TGT_CURCOL: rd_val = DW'(cur_pal_o[32'(idx[1:0]) * RGB_W +: RGB_W]);
      TGT_CTRL:   rd_val = ctrl_q;
      TGT_HSIZE:  rd_val = DW'(hsize_q);
      TGT_VSIZE:  rd_val = DW'({vsize_q, 1'b0});
      default:    rd_val = '0;
    endcase
  end

  // response and external table write ports
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o     <= 1'b0;
      rdata_o     <= '0;
      color_we_o  <= 1'b0;
      color_idx_o <= '0;
      color_rgb_o <= '0;
      pat_we_o    <= 1'b0;
      pat_idx_o   <= '0;
      pat_bits_o  <= '0;
      tbl_clear_o <= 1'b0;
    end else begin
      ready_o     <= req_i;
      rdata_o     <= rd_evt ? rd_val : '0;
      color_we_o  <= wr_evt && (tgt == TGT_COLOR);
      pat_we_o    <= wr_evt && (tgt == TGT_PATTERN);
      tbl_clear_o <= clear_evt;
      if (wr_evt && (tgt == TGT_COLOR)) begin
        color_idx_o <= idx[7:0];
        color_rgb_o <= wdata_i[RGB_W-1:0];
      end
      if (wr_evt && (tgt == TGT_PATTERN)) begin
        pat_idx_o  <= idx;
        pat_bits_o <= wdata_i[PAT_W-1:0];
      end
    end
  end

  disp_depth_decode u_depth (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .code_i (ctrl_q[DEPTH_LSB +: 3]),
    .bpp_o  (depth_bpp_o)
  );

  disp_irq_ctrl u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (frame_done_i),
    .clr_i  (wr_evt),
    .irq_o  (irq_o)
  );

  assign width_px_o   = {hsize_q, 2'b00};
  assign height_ln_o  = vsize_q;
  assign ctrl_o       = ctrl_q;
  assign blank_o      = ctrl_q[BLANK_BIT];
  assign cursor_off_o = ctrl_q[NOCUR_BIT];
  assign top_o        = top_q;
  assign cursor_x_o   = cpos_q[23:12];
  assign cursor_y_o   = cpos_q[11:0];

  assert_ready_follows_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ready_o);

  assert_ready_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ready_o);

  assert_color_port_origin_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    color_we_o |-> ($past(wr_evt) && !pat_we_o && !tbl_clear_o));

  assert_pattern_port_origin_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pat_we_o |-> ($past(wr_evt) && !color_we_o));

  assert_width_scale_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_evt && tgt == TGT_HSIZE) |=> (width_px_o[1:0] == 2'b00));

  assert_clear_all_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_evt && !frame_done_i) |=> (ctrl_o == '0 && top_o == '0 && width_px_o == '0
      && height_ln_o == '0 && cur_pal_o == '0 && tbl_clear_o && !irq_o));

  assert_timing_ignored_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_evt && tgt == TGT_TIMING) |=> ($stable(ctrl_o) && $stable(top_o)
      && $stable(width_px_o) && $stable(height_ln_o) && $stable(cur_pal_o)
      && !color_we_o && !pat_we_o));

  assert_unmapped_read_zero_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_evt && tgt == TGT_NONE) |=> (rdata_o == '0));

endmodule

// File: tb/test_disp_regif.sv
module test_disp_regif;

  localparam int unsigned SIZE_W = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [20:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        frame = 1'b0;

  logic               ready_o;
  logic [31:0]        rdata_o;
  logic               irq_o;
  logic               color_we_o;
  logic [7:0]         color_idx_o;
  logic [23:0]        color_rgb_o;
  logic               pat_we_o;
  logic [8:0]         pat_idx_o;
  logic [15:0]        pat_bits_o;
  logic               tbl_clear_o;
  logic [SIZE_W+1:0]  width_px_o;
  logic [SIZE_W-1:0]  height_ln_o;
  logic [31:0]        ctrl_o;
  logic               blank_o;
  logic               cursor_off_o;
  logic [4:0]         depth_bpp_o;
  logic [31:0]        top_o;
  logic [11:0]        cursor_x_o;
  logic [11:0]        cursor_y_o;
  logic [71:0]        cur_pal_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  disp_regif #(.SIZE_W(SIZE_W)) i_disp_regif (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready_o), .rdata_o(rdata_o), .frame_done_i(frame),
    .irq_o(irq_o), .color_we_o(color_we_o), .color_idx_o(color_idx_o),
    .color_rgb_o(color_rgb_o), .pat_we_o(pat_we_o), .pat_idx_o(pat_idx_o),
    .pat_bits_o(pat_bits_o), .tbl_clear_o(tbl_clear_o), .width_px_o(width_px_o),
    .height_ln_o(height_ln_o), .ctrl_o(ctrl_o), .blank_o(blank_o),
    .cursor_off_o(cursor_off_o), .depth_bpp_o(depth_bpp_o), .top_o(top_o),
    .cursor_x_o(cursor_x_o), .cursor_y_o(cursor_y_o), .cur_pal_o(cur_pal_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one access: request at a falling edge, results read at the next falling edge
  task automatic acc(input logic w, input logic [20:0] a, input logic [31:0] d,
                     input logic fr);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; frame = fr;
    @(negedge clk);
    req = 1'b0; we = 1'b0; frame = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  function automatic logic [4:0] exp_bpp(input int code);
    int t[8] = '{1, 2, 4, 8, 15, 16, 0, 0};
    return 5'(t[code]);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int tmo[14] = '{'h000, 'h108, 'h110, 'h120, 'h128, 'h130, 'h138, 'h140,
                    'h148, 'h158, 'h160, 'h168, 'h170, 'h200};
    int unm[10] = '{'h004, 'h118 + 4, 'h400, 'h638, 'h804, 'h1000, 'h1008,
                    'h2000, 'h100008, 'h0FF000};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 reset ready", 32'(ready_o), 0);
    chk("R1 reset irq", 32'(irq_o), 0);
    chk("R1 reset ctrl", ctrl_o, 0);
    chk("R1 reset width", 32'(width_px_o), 0);
    chk("R1 reset curpal", 32'(|cur_pal_o), 0);
    chk("R1 reset depth code0", 32'(depth_bpp_o), 1);

    // R1 response timing
    acc(1'b0, 21'h300, 0, 1'b0);
    chk("R1 ready after request", 32'(ready_o), 1);
    idle();
    chk("R1 ready drops", 32'(ready_o), 0);

    // R2 colour lookup sweep
    for (int i = 0; i < 256; i++) begin
      logic [23:0] rgb;
      rgb = {8'(i), 8'(255 - i), 8'(i) ^ 8'h5A};
      acc(1'b1, 21'(32'h800 + 8 * i), {8'hC3, rgb}, 1'b0);
      chk("R2 color we", 32'(color_we_o), 1);
      chk("R2 color idx", 32'(color_idx_o), 32'(i));
      chk("R2 color rgb", 32'(color_rgb_o), 32'(rgb));
    end
    idle();
    chk("R2 color we pulse ends", 32'(color_we_o), 0);

    // R4 cursor bitmap sweep
    for (int i = 0; i < 512; i++) begin
      acc(1'b1, 21'(32'h1000 + 8 * i), {16'hDEAD, 16'(i * 37 + 5)}, 1'b0);
      chk("R4 pattern we", 32'(pat_we_o), 1);
      chk("R4 pattern idx", 32'(pat_idx_o), 32'(i));
      chk("R4 pattern bits", 32'(pat_bits_o), 32'(16'(i * 37 + 5)));
      chk("R4 no color we", 32'(color_we_o), 0);
    end
    idle();
    chk("R4 pattern we pulse ends", 32'(pat_we_o), 0);

    // R3 cursor colours
    for (int k = 0; k < 3; k++)
      acc(1'b1, 21'(32'h508 + 8 * k), {8'hFF, 24'(32'h112233 * (k + 1))}, 1'b0);
    for (int k = 0; k < 3; k++) begin
      chk("R3 cursor colour out", 32'(cur_pal_o[k*24 +: 24]), 32'(24'(32'h112233 * (k + 1))));
      acc(1'b0, 21'(32'h508 + 8 * k), 0, 1'b0);
      chk("R3 cursor colour read", rdata_o, 32'(24'(32'h112233 * (k + 1))));
    end

    // R5 width scaling
    for (int v = 0; v < 48; v++) begin
      int vv;
      vv = (v == 47) ? 32'h0000_3FFF : v * 89;
      acc(1'b1, 21'h118, 32'(vv), 1'b0);
      chk("R5 width px", 32'(width_px_o), 32'((vv % 4096) * 4));
      acc(1'b0, 21'h118, 0, 1'b0);
      chk("R5 width read", rdata_o, 32'(vv % 4096));
    end

    // R6 height scaling
    for (int v = 0; v < 48; v++) begin
      int vv;
      vv = (v == 47) ? 32'h0000_3FFF : v * 71 + 1;
      acc(1'b1, 21'h150, 32'(vv), 1'b0);
      chk("R6 height lines", 32'(height_ln_o), 32'((vv / 2) % 4096));
      acc(1'b0, 21'h150, 0, 1'b0);
      chk("R6 height read", rdata_o, 32'(((vv / 2) % 4096) * 2));
    end

    // R7 and R8 control word and depth code
    for (int c = 0; c < 8; c++) begin
      for (int f = 0; f < 4; f++) begin
        logic [31:0] cw;
        cw = (32'(c) << 20) | ((f & 1) != 0 ? 32'h400 : 0)
             | ((f & 2) != 0 ? 32'h0080_0000 : 0) | 32'h0100_0003;
        acc(1'b1, 21'h300, cw, 1'b0);
        chk("R8 depth bpp", 32'(depth_bpp_o), 32'(exp_bpp(c)));
        chk("R7 blank", 32'(blank_o), 32'((f & 1) != 0));
        chk("R7 cursor off", 32'(cursor_off_o), 32'((f & 2) != 0));
        acc(1'b0, 21'h300, 0, 1'b0);
        chk("R7 ctrl read", rdata_o, cw);
      end
    end

    // R9 frame base and cursor position
    acc(1'b1, 21'h400, 32'hA5A5_1234, 1'b0);
    chk("R9 top", top_o, 32'hA5A5_1234);
    acc(1'b1, 21'h638, 32'hFF12_3456, 1'b0);
    chk("R9 cursor x", 32'(cursor_x_o), 32'h123);
    chk("R9 cursor y", 32'(cursor_y_o), 32'h456);

    // R12 timing offsets ignored
    acc(1'b1, 21'h118, 32'd100, 1'b0);
    acc(1'b1, 21'h150, 32'd60, 1'b0);
    acc(1'b1, 21'h300, 32'h0030_0400, 1'b0);
    for (int i = 0; i < 14; i++) begin
      acc(1'b1, 21'(tmo[i]), 32'hFFFF_FFFF, 1'b0);
      chk("R12 ctrl kept", ctrl_o, 32'h0030_0400);
      chk("R12 width kept", 32'(width_px_o), 400);
      chk("R12 height kept", 32'(height_ln_o), 30);
      chk("R12 top kept", top_o, 32'hA5A5_1234);
      chk("R12 no table write", 32'({color_we_o, pat_we_o, tbl_clear_o}), 0);
    end

    // R13 unmapped reads and off-grid writes
    for (int i = 0; i < 10; i++) begin
      acc(1'b0, 21'(unm[i]), 0, 1'b0);
      chk("R13 unmapped read", rdata_o, 0);
    end
    acc(1'b1, 21'h804, 32'h00ABCDEF, 1'b0);
    chk("R13 off-grid colour write", 32'(color_we_o), 0);
    acc(1'b1, 21'h304, 32'hFFFF_FFFF, 1'b0);
    chk("R13 off-grid ctrl write", ctrl_o, 32'h0030_0400);

    // R11 interrupt
    @(negedge clk); frame = 1'b1;
    @(negedge clk); frame = 1'b0;
    chk("R11 irq set", 32'(irq_o), 1);
    acc(1'b0, 21'h300, 0, 1'b0);
    chk("R11 read keeps irq", 32'(irq_o), 1);
    acc(1'b1, 21'h108, 32'h1, 1'b0);
    chk("R11 write clears irq", 32'(irq_o), 0);
    acc(1'b1, 21'h2000, 32'h1, 1'b1);
    chk("R11 set wins over write", 32'(irq_o), 1);
    acc(1'b1, 21'h2000, 32'h1, 1'b0);
    chk("R11 unmapped write clears irq", 32'(irq_o), 0);

    // R10 clear address
    @(negedge clk); frame = 1'b1;
    @(negedge clk); frame = 1'b0;
    acc(1'b1, 21'h100000, 32'h0, 1'b0);
    chk("R10 clear strobe", 32'(tbl_clear_o), 1);
    chk("R10 irq low", 32'(irq_o), 0);
    chk("R10 ctrl zero", ctrl_o, 0);
    chk("R10 top zero", top_o, 0);
    chk("R10 width zero", 32'(width_px_o), 0);
    chk("R10 height zero", 32'(height_ln_o), 0);
    chk("R10 cursor pos zero", 32'({cursor_x_o, cursor_y_o}), 0);
    chk("R10 cursor colours zero", 32'(|cur_pal_o), 0);
    chk("R10 depth back to code0", 32'(depth_bpp_o), 1);
    idle();
    chk("R10 clear strobe ends", 32'(tbl_clear_o), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule